// File: doc/BRIEF.md
# ISA Bus Cycle Sequencer

This block runs one ISA bus cycle at a time for a bus master. Each clock of the block is one SYSCLK. A requester presents a cycle descriptor: memory or I/O, read or write, 8-bit or 16-bit, a 24-bit address, and a refresh flag. The block then drives the matching command strobe, the high-byte enable and the standard memory strobes for the low megabyte. It also drives the cycle address.

The cycle length comes from three inputs. The cycle kind sets a default number of clocks. The slave's zero-wait-state input can end the cycle early, but only for some cycle kinds. The slave's ready input stretches the cycle and always wins over early termination. A watchdog ends any cycle that is stretched too long and flags it.

When the cycle ends, the block returns to idle and pulses a done signal for one clock. While a cycle is in progress the block shows busy, and it does not accept a new request.

Top module: `isa_cycle_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, every active-low strobe (`memr_n`, `memw_n`, `iord_n`, `iowr_n`, `smemr_n`, `smemw_n`, `sbhe_n`) is high. Out of reset, `busy`, `done` and `timeout_err` are low.
- R2: A request is taken only while `busy` is low, on the clock edge where `req_valid` is high. `busy` is high from the following clock until the cycle ends. A `req_valid` raised while `busy` is high is dropped: no cycle follows from it.
- R3: If `zerows_n` stays high and `iochrdy` stays high, the command strobe is low for exactly 3 clocks on a 16-bit cycle (`req_wide`=1) and for exactly 6 clocks on an 8-bit cycle.
- R4: The command clocks are numbered from 1. Suppose `zerows_n` is sampled low together with `iochrdy` high at command clock k, where k is at least 2 on a 16-bit memory cycle or at least 3 on an 8-bit cycle (memory or I/O), and k is below the default length. Then the cycle ends after clock k. The shortest cycles are therefore 2 and 3 clocks.
- R5: `zerows_n` has no effect on a 16-bit I/O cycle. Such a cycle always lasts at least 3 clocks.
- R6: A clock in which `iochrdy` is low never ends the cycle, even if `zerows_n` is low in that clock. From the last default clock onward, the cycle ends at the first clock in which `iochrdy` is sampled high.
- R7: If the cycle reaches `WDOG_CYC` clocks (21 by default) without ending, it is forced to end at that clock. `timeout_err` is then high together with the `done` pulse.
- R8: During a cycle exactly one command strobe is low. Memory read uses `memr_n`, memory write uses `memw_n`, I/O read uses `iord_n` and I/O write uses `iowr_n`. A refresh cycle is always a memory read.
- R9: `smemr_n` and `smemw_n` follow `memr_n` and `memw_n`, but only for addresses of 0x0FFFFF or less. They go low one clock after the command strobe and go high together with it.
- R10: `sbhe_n` is low for the whole cycle when `req_wide`=1 or address bit 0 is 1. It stays high for the whole of a refresh cycle.
- R11: `bus_addr` holds the address latched at acceptance for the whole cycle. On I/O cycles bits [23:16] are driven to zero.
- R12: `done` is high for exactly one clock, the clock after the last command clock. `busy` is low in that same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SYSCLK |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Cycle request |
| req_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit, 0 = 8-bit |
| req_refresh | input | 1 | Refresh cycle |
| req_addr | input | 24 | Cycle address |
| zerows_n | input | 1 | Slave zero-wait-state request, active low |
| iochrdy | input | 1 | Slave ready, low adds wait states |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-clock completion pulse |
| timeout_err | output | 1 | Watchdog forced the end, valid with done |
| memr_n | output | 1 | Memory read command |
| memw_n | output | 1 | Memory write command |
| iord_n | output | 1 | I/O read command |
| iowr_n | output | 1 | I/O write command |
| smemr_n | output | 1 | Low-megabyte memory read |
| smemw_n | output | 1 | Low-megabyte memory write |
| sbhe_n | output | 1 | High byte enable |
| bus_addr | output | 24 | Cycle address |

## Verification
The bench sweeps all eight memory/I/O, read/write and width combinations against six slave response patterns:
- no response;
- zero-wait asserted from the first clock;
- zero-wait asserted from the second clock;
- zero-wait joined by a ready dropout;
- ready stretching on its own;
- late zero-wait.

Each pattern is run at three addresses: above the megabyte boundary, just at it with an odd byte, and below it with an even byte. Zero-wait from clock one versus clock two separates the 16-bit and 8-bit early-end thresholds. The same pattern on 16-bit I/O shows that zero-wait is ignored there. The dropout pattern shows that ready takes priority, and the three addresses separate the strobe qualification from the byte enable. Separate runs cover refresh, the watchdog and a request raised while busy.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;

    localparam int BUS_AW = 24;
    localparam int IO_AW  = 16;

    typedef enum logic {
        SQ_IDLE = 1'b0,
        SQ_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic              is_mem;
        logic              is_wr;
        logic              wide;
        logic              refresh;
        logic [BUS_AW-1:0] addr;
    } isa_req_t;

    // A refresh is carried out as a memory read.
    function automatic isa_req_t req_normalize(input isa_req_t r);
        isa_req_t o;
        o = r;
        if (r.refresh) begin
            o.is_mem = 1'b1;
            o.is_wr  = 1'b0;
        end
        return o;
    endfunction

    function automatic logic [BUS_AW-1:0] io_mask(input logic [BUS_AW-1:0] a);
        logic [BUS_AW-1:0] o;
        o = '0;
        o[IO_AW-1:0] = a[IO_AW-1:0];
        return o;
    endfunction

endpackage

// File: rtl/isa_wait_timer.sv
module isa_wait_timer
    import isa_seq_pkg::*;
#(
    parameter int DEF16    = 3,
    parameter int DEF8     = 6,
    parameter int ZWS16    = 2,
    parameter int ZWS8     = 3,
    parameter int WDOG_CYC = 21,
    parameter int CNT_W    = $clog2(WDOG_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    input  logic             wide,
    input  logic             is_io,
    input  logic             zerows_n,
    input  logic             iochrdy,
    output logic [CNT_W-1:0] cnt,
    output logic             fin,
    output logic             tmo
);
    localparam logic [CNT_W-1:0] C_DEF16 = CNT_W'(DEF16);
    localparam logic [CNT_W-1:0] C_DEF8  = CNT_W'(DEF8);
    localparam logic [CNT_W-1:0] C_ZWS16 = CNT_W'(ZWS16);
    localparam logic [CNT_W-1:0] C_ZWS8  = CNT_W'(ZWS8);
    localparam logic [CNT_W-1:0] C_WDOG  = CNT_W'(WDOG_CYC);
    localparam logic [CNT_W-1:0] C_ONE   = CNT_W'(1);

    logic [CNT_W-1:0] def_len;
    logic [CNT_W-1:0] zws_len;
    logic             zws_allowed;
    logic             early_end;
    logic             normal_end;
    logic             wdog_hit;

    // cnt holds the number of the command clock now in progress.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= C_ONE;
        end else if (active && !fin) begin
            cnt <= cnt + C_ONE;
        end
    end

    always_comb begin
        def_len     = wide ? C_DEF16 : C_DEF8;
        zws_len     = wide ? C_ZWS16 : C_ZWS8;
        zws_allowed = !(is_io && wide);
        // The ready input has priority: zero-wait counts only with ready high.
        early_end   = zws_allowed && !zerows_n && iochrdy
                      && (cnt >= zws_len) && (cnt < def_len);
        normal_end  = (cnt >= def_len) && iochrdy;
        wdog_hit    = (cnt >= C_WDOG);
        fin         = active && (early_end || normal_end || wdog_hit);
        tmo         = active && wdog_hit && !early_end && !normal_end;
    end

endmodule

// File: rtl/isa_strobe_gen.sv
module isa_strobe_gen
    import isa_seq_pkg::*;
#(
    parameter logic [BUS_AW-1:0] LOW_MEM_TOP = 24'h0F_FFFF,
    parameter int                CNT_W       = 5
) (
    input  logic              active,
    input  isa_req_t          req,
    input  logic [CNT_W-1:0]  cnt,
    output logic              memr_n,
    output logic              memw_n,
    output logic              iord_n,
    output logic              iowr_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              sbhe_n,
    output logic [BUS_AW-1:0] bus_addr
);
    localparam logic [CNT_W-1:0] C_TWO = CNT_W'(2);

    logic low_meg;
    logic late;
    logic mem_rd;
    logic mem_wr;

    always_comb begin
        low_meg  = (req.addr <= LOW_MEM_TOP);
        late     = (cnt >= C_TWO);
        mem_rd   = active && req.is_mem && !req.is_wr;
        mem_wr   = active && req.is_mem && req.is_wr;
        memr_n   = !mem_rd;
        memw_n   = !mem_wr;
        iord_n   = !(active && !req.is_mem && !req.is_wr);
        iowr_n   = !(active && !req.is_mem && req.is_wr);
        smemr_n  = !(mem_rd && low_meg && late);
        smemw_n  = !(mem_wr && low_meg && late);
        sbhe_n   = !(active && !req.refresh && (req.wide || req.addr[0]));
        bus_addr = req.is_mem ? req.addr : io_mask(req.addr);
    end

endmodule

// File: rtl/isa_cycle_seq.sv
module isa_cycle_seq
    import isa_seq_pkg::*;
#(
    parameter int                DEF16       = 3,
    parameter int                DEF8        = 6,
    parameter int                ZWS16       = 2,
    parameter int                ZWS8        = 3,
    parameter int                WDOG_CYC    = 21,
    parameter logic [BUS_AW-1:0] LOW_MEM_TOP = 24'h0F_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_mem,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic              req_refresh,
    input  logic [BUS_AW-1:0] req_addr,
    input  logic              zerows_n,
    input  logic              iochrdy,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic              memr_n,
    output logic              memw_n,
    output logic              iord_n,
    output logic              iowr_n,
    output logic              smemr_n,
    output logic              smemw_n,
    output logic              sbhe_n,
    output logic [BUS_AW-1:0] bus_addr
);
    localparam int CNT_W = $clog2(WDOG_CYC + 1);

    seq_state_e       state;
    isa_req_t         req_in;
    isa_req_t         req_q;
    logic             start;
    logic             active;
    logic             fin;
    logic             tmo;
    logic             done_q;
    logic             err_q;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        req_in.is_mem  = req_mem;
        req_in.is_wr   = req_write;
        req_in.wide    = req_wide;
        req_in.refresh = req_refresh;
        req_in.addr    = req_addr;
        active         = (state == SQ_RUN);
        start          = (state == SQ_IDLE) && req_valid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            req_q  <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_normalize(req_in);
                        state <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (fin) begin
                        state  <= SQ_IDLE;
                        done_q <= 1'b1;
                        err_q  <= tmo;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    isa_wait_timer #(
        .DEF16   (DEF16),
        .DEF8    (DEF8),
        .ZWS16   (ZWS16),
        .ZWS8    (ZWS8),
        .WDOG_CYC(WDOG_CYC),
        .CNT_W   (CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .active  (active),
        .wide    (req_q.wide),
        .is_io   (!req_q.is_mem),
        .zerows_n(zerows_n),
        .iochrdy (iochrdy),
        .cnt     (cnt),
        .fin     (fin),
        .tmo     (tmo)
    );

    isa_strobe_gen #(
        .LOW_MEM_TOP(LOW_MEM_TOP),
        .CNT_W      (CNT_W)
    ) u_strobe (
        .active  (active),
        .req     (req_q),
        .cnt     (cnt),
        .memr_n  (memr_n),
        .memw_n  (memw_n),
        .iord_n  (iord_n),
        .iowr_n  (iowr_n),
        .smemr_n (smemr_n),
        .smemw_n (smemw_n),
        .sbhe_n  (sbhe_n),
        .bus_addr(bus_addr)
    );

    assign busy        = active;
    assign done        = done_q;
    assign timeout_err = err_q;

endmodule

// File: rtl/isa_cycle_seq_chk.sv
module isa_cycle_seq_chk
    import isa_seq_pkg::*;
#(
    parameter int DEF16    = 3,
    parameter int DEF8     = 6,
    parameter int WDOG_CYC = 21,
    parameter int CNT_W    = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              done,
    input logic              timeout_err,
    input logic              memr_n,
    input logic              memw_n,
    input logic              iord_n,
    input logic              iowr_n,
    input logic              smemr_n,
    input logic              smemw_n,
    input logic              sbhe_n,
    input logic [BUS_AW-1:0] bus_addr,
    input logic              iochrdy,
    input logic [CNT_W-1:0]  cnt,
    input isa_req_t          req_q
);
    logic [CNT_W-1:0] dl;
    assign dl = req_q.wide ? CNT_W'(DEF16) : CNT_W'(DEF8);

    p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (memr_n && memw_n && iord_n && iowr_n && smemr_n && smemw_n && sbhe_n));

    p_one_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        busy |-> ($countones({~memr_n, ~memw_n, ~iord_n, ~iowr_n}) == 1));

    p_smemr_sub_r9: assert property (@(posedge clk) disable iff (rst)
        !smemr_n |-> !memr_n);

    p_smemw_sub_r9: assert property (@(posedge clk) disable iff (rst)
        !smemw_n |-> !memw_n);

    p_smem_late_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(memr_n) |-> smemr_n);

    p_refresh_sbhe_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && req_q.refresh) |-> sbhe_n);

    p_io_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !req_q.is_mem) |-> (bus_addr[BUS_AW-1:IO_AW] == '0));

    p_min_len_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |=> busy);

    p_ready_wait_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && !iochrdy && cnt >= dl && cnt < CNT_W'(WDOG_CYC)) |=> busy);

    p_tmo_done_r7: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> done);

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

endmodule

bind isa_cycle_seq isa_cycle_seq_chk #(
    .DEF16   (DEF16),
    .DEF8    (DEF8),
    .WDOG_CYC(WDOG_CYC),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .timeout_err(timeout_err),
    .memr_n     (memr_n),
    .memw_n     (memw_n),
    .iord_n     (iord_n),
    .iowr_n     (iowr_n),
    .smemr_n    (smemr_n),
    .smemw_n    (smemw_n),
    .sbhe_n     (sbhe_n),
    .bus_addr   (bus_addr),
    .iochrdy    (iochrdy),
    .cnt        (cnt),
    .req_q      (req_q)
);

// File: tb/isa_cycle_seq_tb.sv
module isa_cycle_seq_tb;
    localparam int WD = 21;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_mem = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic        req_refresh = 1'b0;
    logic [23:0] req_addr = '0;
    logic        zerows_n = 1'b1;
    logic        iochrdy = 1'b1;
    logic        busy, done, timeout_err;
    logic        memr_n, memw_n, iord_n, iowr_n, smemr_n, smemw_n, sbhe_n;
    logic [23:0] bus_addr;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    isa_cycle_seq u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mem(req_mem),
        .req_write(req_write), .req_wide(req_wide), .req_refresh(req_refresh),
        .req_addr(req_addr), .zerows_n(zerows_n), .iochrdy(iochrdy),
        .busy(busy), .done(done), .timeout_err(timeout_err),
        .memr_n(memr_n), .memw_n(memw_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .smemr_n(smemr_n), .smemw_n(smemw_n), .sbhe_n(sbhe_n), .bus_addr(bus_addr)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected length and timeout from the requirements (R3..R7).
    task automatic expect_len(input bit io, input bit wide, input int z, input int r0,
                              input int rl, output int len, output bit tmo);
        int zl;
        int dl;
        zl  = wide ? 2 : 3;
        dl  = wide ? 3 : 6;
        len = WD;
        tmo = 1'b1;
        for (int k = 1; k <= WD; k++) begin
            bit rdy;
            bit zw;
            rdy = !(r0 != 0 && k >= r0 && k < r0 + rl);
            zw  = (z != 0 && k >= z);
            if ((!(io && wide) && zw && rdy && k >= zl && k < dl) || (k >= dl && rdy)) begin
                len = k;
                tmo = 1'b0;
                break;
            end
        end
    endtask

    task automatic run_cycle(input bit m, input bit w, input bit wd, input bit rf,
                             input logic [23:0] a, input int z, input int r0, input int rl);
        bit em;
        bit ew;
        bit io;
        int exp_len;
        bit exp_tmo;
        int len;
        int k;
        bit low_meg;
        bit cmd_bad;
        bit other_bad;
        bit smem_bad;
        bit sbhe_bad;
        bit addr_bad;
        bit busy_bad;
        logic [23:0] exp_addr;
        logic cmd;
        logic oth;
        logic exp_smem;
        logic act_smem;
        em = m | rf;
        ew = w & ~rf;
        io = ~em;
        expect_len(io, wd, z, r0, rl, exp_len, exp_tmo);
        low_meg  = (a <= 24'h0FFFFF);
        exp_addr = io ? {8'h00, a[15:0]} : a;
        cmd_bad = 0; other_bad = 0; smem_bad = 0; sbhe_bad = 0; addr_bad = 0; busy_bad = 0;
        len = 0;
        @(negedge clk);
        req_valid = 1'b1; req_mem = m; req_write = w; req_wide = wd;
        req_refresh = rf; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        k = 1;
        while (!done && k < 60) begin
            zerows_n = !(z != 0 && k >= z);
            iochrdy  = !(r0 != 0 && k >= r0 && k < r0 + rl);
            case ({em, ew})
                2'b10:   begin cmd = memr_n; oth = memw_n & iord_n & iowr_n; end
                2'b11:   begin cmd = memw_n; oth = memr_n & iord_n & iowr_n; end
                2'b00:   begin cmd = iord_n; oth = memr_n & memw_n & iowr_n; end
                default: begin cmd = iowr_n; oth = memr_n & memw_n & iord_n; end
            endcase
            if (!cmd) len++;
            if (!oth) other_bad = 1;
            if (!busy) busy_bad = 1;
            exp_smem = !(em && low_meg && k >= 2);
            act_smem = ew ? smemw_n : smemr_n;
            if (act_smem !== exp_smem || (ew ? !smemr_n : !smemw_n)) smem_bad = 1;
            if (sbhe_n !== !(!rf && (wd || a[0]))) sbhe_bad = 1;
            if (bus_addr !== exp_addr) addr_bad = 1;
            @(negedge clk);
            k++;
        end
        zerows_n = 1'b1; iochrdy = 1'b1;
        if (exp_tmo)
            check(len == exp_len, "R7 watchdog length", len, exp_len);
        else if (z != 0 && r0 == 0)
            check(len == exp_len, "R4/R5 zero-wait length", len, exp_len);
        else if (r0 != 0)
            check(len == exp_len, "R6 ready length", len, exp_len);
        else
            check(len == exp_len, "R3 default length", len, exp_len);
        check(!cmd_bad && !other_bad, "R8 command select", other_bad, 0);
        check(!smem_bad, "R9 low-meg strobe", smem_bad, 0);
        check(!sbhe_bad, "R10 byte enable", sbhe_bad, 0);
        check(!addr_bad, "R11 address", addr_bad, 0);
        check(!busy_bad, "R2 busy during cycle", busy_bad, 0);
        check(done === 1'b1 && busy === 1'b0, "R12 done end", {done, busy}, 2'b10);
        check(timeout_err === exp_tmo, "R7 timeout flag", timeout_err, exp_tmo);
        check((memr_n & memw_n & iord_n & iowr_n & smemr_n & smemw_n & sbhe_n) === 1'b1,
              "R1 idle strobes", {memr_n, memw_n, iord_n, iowr_n}, 4'hF);
        @(negedge clk);
        check(done === 1'b0, "R12 done single", done, 0);
    endtask

    initial begin
        logic [23:0] addrs [3];
        addrs[0] = 24'h0FFFFF;
        addrs[1] = 24'h100000;
        addrs[2] = 24'h03A5C4;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && timeout_err === 1'b0, "R1 reset flags",
              {busy, done, timeout_err}, 0);
        check((memr_n & memw_n & iord_n & iowr_n & smemr_n & smemw_n & sbhe_n) === 1'b1,
              "R1 reset strobes", {memr_n, memw_n, iord_n, iowr_n}, 4'hF);
        rst = 1'b0;
        for (int m = 0; m < 2; m++)
            for (int w = 0; w < 2; w++)
                for (int wd = 0; wd < 2; wd++)
                    for (int p = 0; p < 6; p++)
                        for (int ai = 0; ai < 3; ai++) begin
                            int z;
                            int r0;
                            int rl;
                            case (p)
                                0: begin z = 0; r0 = 0; rl = 0; end
                                1: begin z = 1; r0 = 0; rl = 0; end
                                2: begin z = 2; r0 = 0; rl = 0; end
                                3: begin z = 1; r0 = 1; rl = 4; end
                                4: begin z = 0; r0 = 2; rl = 6; end
                                default: begin z = 4; r0 = 0; rl = 0; end
                            endcase
                            run_cycle(m[0], w[0], wd[0], 1'b0, addrs[ai], z, r0, rl);
                        end
        // Refresh: memory read, byte enable held high (R10, R8).
        run_cycle(1'b0, 1'b1, 1'b1, 1'b1, 24'h000013, 0, 0, 0);
        run_cycle(1'b0, 1'b0, 1'b0, 1'b1, 24'h000021, 2, 0, 0);
        // Watchdog (R7).
        run_cycle(1'b1, 1'b0, 1'b1, 1'b0, 24'h000100, 1, 1, 100);
        run_cycle(1'b0, 1'b1, 1'b0, 1'b0, 24'h000301, 0, 3, 100);
        // Request while busy is dropped (R2).
        @(negedge clk);
        req_valid = 1'b1; req_mem = 1'b0; req_write = 1'b0; req_wide = 1'b0;
        req_refresh = 1'b0; req_addr = 24'h000060;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_mem = 1'b1; req_write = 1'b1; req_wide = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(busy === 1'b0 && memw_n === 1'b1, "R2 busy request dropped", {busy, memw_n}, 2'b01);
        @(negedge clk);
        check(busy === 1'b0, "R2 no late cycle", busy, 0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run hung actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule